// File: doc/BRIEF.md
# Full-Speed Start-of-Frame Timer

This block sets the frame cadence of a full-speed host controller. A programmable frame length, counted in bit times, is held in an interval register. A 14-bit down counter holds the bit times left in the running frame. When that counter has reached zero, the next bit-time enable begins a new frame:

- the counter reloads from the interval;
- a one-cycle start-of-frame strobe is raised;
- a second counter is loaded with the largest-packet budget for the new frame.

The budget counter drains while a transfer is active. The scheduler uses it to judge whether another transaction still fits before the frame ends.

Software reaches both registers through a command port. Each register has its own read code and write code, and bit 7 of the code marks a write. The interval register also carries a software-driven toggle bit that tags each update. Each reload copies it into the remaining-time register, so software can see when a new interval has reached the running frame. A host-controller reset input restores the nominal 12000-bit-time frame.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset, the interval register reads 0x00002EDF (frame length 11999, toggle 0, packet budget 0). The remaining-time register reads 0. sofPulse is 0, and budgetEmpty is 1.
- R2: Command code 0x8D writes the interval register: bit 31 is the toggle, bits 30:16 are the packet budget and bits 13:0 are the frame length. Code 0x0D reads it back in the same layout with bits 15:14 as zero. Any other read code returns 0.
- R3: Code 0x8E writes the remaining-time register (bit 31 toggle, bits 13:0 count). Code 0x0E reads it with bits 30:14 as zero. For every read, rdData holds the result from the clock edge that samples the command.
- R4: With runEn high and a nonzero count, each bitTick lowers the remaining count by exactly one.
- R5: A bitTick that finds the count at zero reloads it with the frame length and raises sofPulse for one cycle. Frames are therefore frame length + 1 bit times apart.
- R6: At each reload, the interval toggle bit is copied into the remaining-time toggle bit.
- R7: At each reload, budgetLeft takes the packet budget. It then drops by one on each counting bitTick while xferActive is high, stops at zero, and budgetEmpty is high whenever it is zero.
- R8: While runEn is low, bitTick changes neither counter and sofPulse stays low.
- R9: A hcReset pulse sets the frame length to 11999 and leaves the toggle and packet budget fields unchanged.
- R10: A frame length written in the middle of a frame is used only at the next reload.
- R11: A remaining-time write in the same cycle as a bitTick wins: the written value is kept, and no decrement, reload or start-of-frame strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hcReset | input | 1 | Host-controller reset command; restores the nominal frame length |
| runEn | input | 1 | Operational state; the counters run only while high |
| bitTick | input | 1 | One-cycle enable per bit time |
| xferActive | input | 1 | A transfer is using the bus; drains the budget counter |
| cmdValid | input | 1 | Command strobe for the register port |
| cmdCode | input | 8 | Command code; bit 7 set means write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| sofPulse | output | 1 | One-cycle start-of-frame strobe |
| budgetLeft | output | 15 | Bits the current frame can still move in one transaction |
| budgetEmpty | output | 1 | High when budgetLeft is zero |

## Verification
Every result is due one clock edge after its stimulus:

- a bitTick sampled at an edge changes the count, the budget and sofPulse at that edge;
- a read command puts its value on rdData at the edge that samples it.

The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore sees the value registered at the single rising edge in between. Frame spacing is measured by counting single ticks until sofPulse appears, and is compared with frame length + 1.

// File: rtl/sof_timer_pkg.sv
package sof_timer_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CODE_W     = 8;
  localparam int unsigned FRAME_W    = 14;
  localparam int unsigned BUDGET_W   = 15;
  localparam int unsigned TOGGLE_BIT = 31;
  localparam int unsigned BUDGET_LSB = 16;
  localparam int unsigned WRITE_BIT  = 7;

  localparam logic [FRAME_W-1:0] FRAME_NOMINAL = 14'd11999;
  localparam logic [CODE_W-2:0]  ADDR_INTERVAL = 7'h0D;
  localparam logic [CODE_W-2:0]  ADDR_REMAIN   = 7'h0E;

  // Strobes passed from control to datapath, one cycle's worth of work.
  typedef struct packed {
    logic wrInterval;
    logic wrRemain;
    logic rdInterval;
    logic rdRemain;
    logic rdOther;
    logic hcRst;
    logic decRem;
    logic reload;
    logic decBudget;
  } tmrStrobe_t;
endpackage

// File: rtl/sof_timer_ctrl.sv
module sof_timer_ctrl
  import sof_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              hcReset,
  input  logic              bitTick,
  input  logic              runEn,
  input  logic              xferActive,
  input  logic              remZero,
  input  logic              budgetZero,
  output tmrStrobe_t        strb,
  output logic              sofPulse
);
  logic             isWrite;
  logic [CODE_W-2:0] addr;
  logic             countStep;

  assign isWrite = cmdCode[WRITE_BIT];
  assign addr    = cmdCode[CODE_W-2:0];

  always_comb begin
    strb            = '0;
    strb.wrInterval = cmdValid && isWrite && (addr == ADDR_INTERVAL);
    strb.wrRemain   = cmdValid && isWrite && (addr == ADDR_REMAIN);
    strb.rdInterval = cmdValid && !isWrite && (addr == ADDR_INTERVAL);
    strb.rdRemain   = cmdValid && !isWrite && (addr == ADDR_REMAIN);
    strb.rdOther    = cmdValid && !isWrite &&
                      (addr != ADDR_INTERVAL) && (addr != ADDR_REMAIN);
    strb.hcRst      = hcReset;
    // A software write to the remaining count owns this cycle (R11).
    countStep       = bitTick && runEn && !strb.wrRemain;
    strb.reload     = countStep && remZero;
    strb.decRem     = countStep && !remZero;
    strb.decBudget  = countStep && !remZero && xferActive && !budgetZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sofPulse <= 1'b0;
    else       sofPulse <= strb.reload;
  end

  // R5: a frame boundary is followed by the strobe
  p_sof_follows_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> sofPulse);

  // R8: idle state never produces a strobe
  p_no_sof_when_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !sofPulse);

  // R11: register write blocks any frame boundary in that cycle
  p_write_blocks_sof_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 8'h8E) |=> !sofPulse);
endmodule

// File: rtl/sof_timer_dp.sv
module sof_timer_dp
  import sof_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                remZero,
  output logic                budgetZero,
  output logic [BUDGET_W-1:0] budgetLeft
);
  localparam int unsigned RSV_IV_W  = BUDGET_LSB - FRAME_W;
  localparam int unsigned RSV_REM_W = TOGGLE_BIT - FRAME_W;

  logic                frameLen;
  logic [FRAME_W-1:0]  frameLenQ;
  logic                ivToggle;
  logic [BUDGET_W-1:0] pktBudget;
  logic [FRAME_W-1:0]  remCnt;
  logic                remToggle;
  logic [BUDGET_W-1:0] budgetCnt;
  logic [DATA_W-1:0]   ivWord;
  logic [DATA_W-1:0]   remWord;
  logic                unusedWrBits;

  assign frameLen     = 1'b0;
  assign unusedWrBits = ^{frameLen, wrData[TOGGLE_BIT-1:FRAME_W]};

  // Interval register: toggle, packet budget, frame length.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameLenQ <= FRAME_NOMINAL;
      ivToggle  <= 1'b0;
      pktBudget <= '0;
    end else begin
      if (strb.hcRst)           frameLenQ <= FRAME_NOMINAL;
      else if (strb.wrInterval) frameLenQ <= wrData[FRAME_W-1:0];
      if (strb.wrInterval) begin
        ivToggle  <= wrData[TOGGLE_BIT];
        pktBudget <= wrData[BUDGET_LSB +: BUDGET_W];
      end
    end
  end

  // Remaining bit-time counter with its toggle copy.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt    <= '0;
      remToggle <= 1'b0;
    end else if (strb.wrRemain) begin
      remCnt    <= wrData[FRAME_W-1:0];
      remToggle <= wrData[TOGGLE_BIT];
    end else if (strb.reload) begin
      remCnt    <= frameLenQ;
      remToggle <= ivToggle;
    end else if (strb.decRem) begin
      remCnt    <= remCnt - 1'b1;
    end
  end

  // Largest-packet budget counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               budgetCnt <= '0;
    else if (strb.reload)    budgetCnt <= pktBudget;
    else if (strb.decBudget) budgetCnt <= budgetCnt - 1'b1;
  end

  assign ivWord  = {ivToggle, pktBudget, {RSV_IV_W{1'b0}}, frameLenQ};
  assign remWord = {remToggle, {RSV_REM_W{1'b0}}, remCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strb.rdInterval) rdData <= ivWord;
    else if (strb.rdRemain)   rdData <= remWord;
    else if (strb.rdOther)    rdData <= '0;
  end

  assign remZero    = (remCnt == '0);
  assign budgetZero = (budgetCnt == '0);
  assign budgetLeft = budgetCnt;

  // R4: each counting step removes exactly one bit time
  p_dec_by_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.decRem |=> remCnt == $past(remCnt) - 1'b1);

  // R5 / R10: reload uses the frame length held before the edge
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> remCnt == $past(frameLenQ));

  // R6: toggle copied at reload
  p_toggle_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> remToggle == $past(ivToggle));

  // R7: budget never wraps below zero
  p_budget_floor_r7: assert property (@(posedge clk) disable iff (!rstN)
    (budgetZero && !strb.reload) |=> budgetZero);

  // R8: without a step or a write the count holds
  p_hold_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.decRem && !strb.reload && !strb.wrRemain) |=> $stable(remCnt));

  // R9: host-controller reset restores the nominal length
  p_hc_nominal_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.hcRst |=> frameLenQ == FRAME_NOMINAL);
endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer
  import sof_timer_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hcReset,
  input  logic                runEn,
  input  logic                bitTick,
  input  logic                xferActive,
  input  logic                cmdValid,
  input  logic [CODE_W-1:0]   cmdCode,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                sofPulse,
  output logic [BUDGET_W-1:0] budgetLeft,
  output logic                budgetEmpty
);
  tmrStrobe_t strb;
  logic       remZero;
  logic       budgetZero;

  sof_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .hcReset    (hcReset),
    .bitTick    (bitTick),
    .runEn      (runEn),
    .xferActive (xferActive),
    .remZero    (remZero),
    .budgetZero (budgetZero),
    .strb       (strb),
    .sofPulse   (sofPulse)
  );

  sof_timer_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .rdData     (rdData),
    .remZero    (remZero),
    .budgetZero (budgetZero),
    .budgetLeft (budgetLeft)
  );

  assign budgetEmpty = budgetZero;
endmodule

// File: tb/sof_frame_timer_bench.sv
module sof_frame_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hcReset = 1'b0;
  logic        runEn = 1'b0;
  logic        bitTick = 1'b0;
  logic        xferActive = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdCode = 8'h00;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        sofPulse;
  logic [14:0] budgetLeft;
  logic        budgetEmpty;

  int compared = 0;
  int mismatched = 0;

  sof_frame_timer u_sof_frame_timer (
    .clk(clk), .rstN(rstN), .hcReset(hcReset), .runEn(runEn),
    .bitTick(bitTick), .xferActive(xferActive), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .wrData(wrData), .rdData(rdData),
    .sofPulse(sofPulse), .budgetLeft(budgetLeft), .budgetEmpty(budgetEmpty)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] ivWord(logic tog, logic [14:0] pk, logic [13:0] fl);
    return {tog, pk, 2'b00, fl};
  endfunction

  function automatic logic [31:0] remWord(logic tog, logic [13:0] cnt);
    return {tog, 17'b0, cnt};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [7:0] code, logic [31:0] data);
    cmdValid = 1'b1; cmdCode = code; wrData = data; bitTick = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readReg(logic [7:0] code, output logic [31:0] val);
    cmdValid = 1'b1; cmdCode = code; bitTick = 1'b0;
    @(negedge clk);
    val = rdData;
    cmdValid = 1'b0;
  endtask

  // Issues n single-cycle ticks and counts the strobes seen after each.
  task automatic ticks(int n, output int sofs);
    sofs = 0;
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      if (sofPulse) sofs++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sofPulse", {31'b0, sofPulse}, 32'd0);
    chk("R1 budgetEmpty", {31'b0, budgetEmpty}, 32'd1);
    readReg(8'h0D, v); chk("R1 interval", v, 32'h0000_2EDF);
    readReg(8'h0E, v); chk("R1 remaining", v, 32'd0);
  endtask

  task automatic t_registers();
    logic [31:0] v;
    writeReg(8'h8D, 32'hFFFF_C014);
    readReg(8'h0D, v); chk("R2 interval layout", v, 32'hFFFF_0014);
    readReg(8'h0F, v); chk("R2 other read code", v, 32'd0);
    writeReg(8'h8E, 32'hFFFF_C005);
    readReg(8'h0E, v); chk("R3 remaining layout", v, 32'h8000_0005);
  endtask

  task automatic t_counting();
    logic [31:0] v;
    int s;
    int period;
    writeReg(8'h8D, ivWord(1'b1, 15'd300, 14'd20));
    writeReg(8'h8E, remWord(1'b0, 14'd5));
    runEn = 1'b1;
    ticks(1, s); readReg(8'h0E, v); chk("R4 first decrement", v, 32'd4);
    ticks(4, s); chk("R4 no early sof", s, 0);
    readReg(8'h0E, v); chk("R4 reaches zero", v, 32'd0);
    ticks(1, s); chk("R5 sof at boundary", s, 1);
    chk("R7 budget loaded", {17'b0, budgetLeft}, 32'd300);
    readReg(8'h0E, v);
    chk("R6 toggle copied, reload value R5", v, remWord(1'b1, 14'd20));
    chk("R5 sof one cycle", {31'b0, sofPulse}, 32'd0);
    period = 0;
    for (int i = 0; i < 100; i++) begin
      ticks(1, s); period++;
      if (s != 0) break;
    end
    chk("R5 frame period", period, 21);
  endtask

  task automatic t_budget();
    int s;
    writeReg(8'h8D, ivWord(1'b0, 15'd3, 14'd10));
    writeReg(8'h8E, 32'd0);
    ticks(1, s);
    chk("R7 reload budget", {17'b0, budgetLeft}, 32'd3);
    ticks(1, s);
    chk("R7 idle transfer holds", {17'b0, budgetLeft}, 32'd3);
    xferActive = 1'b1;
    ticks(3, s);
    chk("R7 drains to zero", {17'b0, budgetLeft}, 32'd0);
    ticks(2, s);
    chk("R7 saturates", {17'b0, budgetLeft}, 32'd0);
    chk("R7 empty flag", {31'b0, budgetEmpty}, 32'd1);
    xferActive = 1'b0;
  endtask

  task automatic t_idle();
    logic [31:0] v;
    int s;
    readReg(8'h0E, v); chk("R8 start count", v, 32'd4);
    runEn = 1'b0;
    ticks(5, s);
    readReg(8'h0E, v); chk("R8 count held", v, 32'd4);
    writeReg(8'h8E, 32'd0);
    ticks(3, s); chk("R8 no sof while idle", s, 0);
    readReg(8'h0E, v); chk("R8 zero held", v, 32'd0);
    runEn = 1'b1;
  endtask

  task automatic t_hc_reset();
    logic [31:0] v;
    writeReg(8'h8D, ivWord(1'b1, 15'd50, 14'd100));
    hcReset = 1'b1;
    @(negedge clk);
    hcReset = 1'b0;
    readReg(8'h0D, v); chk("R9 nominal restored", v, ivWord(1'b1, 15'd50, 14'd11999));
  endtask

  task automatic t_mid_frame();
    logic [31:0] v;
    int s;
    writeReg(8'h8D, ivWord(1'b0, 15'd0, 14'd8));
    writeReg(8'h8E, 32'd0);
    ticks(1, s); chk("R5 boundary", s, 1);
    ticks(2, s);
    readReg(8'h0E, v); chk("R10 before update", v, 32'd6);
    writeReg(8'h8D, ivWord(1'b0, 15'd0, 14'd30));
    ticks(6, s); chk("R10 frame not cut", s, 0);
    readReg(8'h0E, v); chk("R10 old frame finishes", v, 32'd0);
    ticks(1, s); chk("R10 boundary", s, 1);
    readReg(8'h0E, v); chk("R10 new length used", v, 32'd30);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    cmdValid = 1'b1; cmdCode = 8'h8E; wrData = 32'd9; bitTick = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; bitTick = 1'b0;
    readReg(8'h0E, v); chk("R11 write beats decrement", v, 32'd9);
    writeReg(8'h8E, 32'd0);
    cmdValid = 1'b1; cmdCode = 8'h8E; wrData = 32'd4; bitTick = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; bitTick = 1'b0;
    chk("R11 no sof on write", {31'b0, sofPulse}, 32'd0);
    readReg(8'h0E, v); chk("R11 write beats reload", v, 32'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_registers();
    t_counting();
    t_budget();
    t_idle();
    t_hc_reset();
    t_mid_frame();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule